// File: doc/BRIEF.md
# NAND Flash Cycle Strobe Sequencer

This block turns single bus-cycle requests (command byte, address byte, write data byte, read data byte) into the chip-enable, latch-enable and read/write strobe waveforms a NAND flash device expects. Each request runs through a setup phase, a strobe phase and a hold phase. The length of each phase comes from an 8-bit cycle count. On writes, a separate count keeps the data bus undriven at the start of the cycle. Two complete timing sets are held on input pins, one for the common memory space and one for the attribute memory space. A per-request space bit picks the set, and it is sampled when the request is accepted.

Before a read strobe, the sequencer makes sure that enough cycles have passed since the command latch line and the address latch line last went low. Each of these two minimum gaps has its own programmable count. The ready/busy line from the device passes through a two-flop synchroniser. It can stall new requests while the device is busy, and it raises sticky event flags for a rising edge, a high level and a falling edge. Each flag has its own interrupt enable.

Requests enter on a valid/ready handshake. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the sequencer is idle and no busy stall applies. Read bytes leave on a second valid/ready handshake. `rd_valid` and `rd_data` hold steady until `rd_ready` is seen high, and no new request is accepted until then.

Top module: `nand_cycle_sequencer`

## Requirements
- R1: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale` and `nand_dq_oe` are low, `rd_valid`, `evt_flags` and `irq` are zero, and `req_ready` is high.
- R2: `req_kind` encodes 0 = command, 1 = address, 2 = write data, 3 = read data. For a command (address) request, counting access cycles from 0 at the cycle after acceptance, `nand_we_n` first goes low at cycle `setup` and stays low for `strobe`+1 cycles. `nand_cle` (`nand_ale`) is high and `nand_ce_n` is low for the whole access, and the byte is driven on `nand_dq_out` with `nand_dq_oe` high from cycle 0.
- R3: After the write strobe rises, `nand_ce_n`, the latch line and the driven byte remain for exactly `hold` further cycles, and then the sequencer returns to idle.
- R4: On a write-data request, `nand_dq_oe` stays low for the first `hiz` access cycles. The write strobe is not asserted before the bus is driven, so it first goes low at access cycle max(`setup`, `hiz`).
- R5: `req_space` = 0 selects the common timing set (`com_*`) and 1 selects the attribute set (`att_*`). The other set has no effect on that access.
- R6: A read request pulses `nand_re_n` low for `strobe`+1 cycles and samples `nand_dq_in` on the last strobe cycle. The byte is then presented with `rd_valid` high and held stable, with `req_ready` low, until `rd_ready` is high on a clock edge.
- R7: The first low cycle of `nand_re_n` comes at least `cle_re_dly` cycles after the first low cycle of `nand_cle`. When a read with setup `s` is accepted in that first low cycle, the gap is exactly max(`cle_re_dly`, `s`+1).
- R8: The same rule applies between the first low cycle of `nand_ale` and the read strobe, using `ale_re_dly`.
- R9: With `wait_en` high, `req_ready` stays low while the synchronised `nand_rb` is low (busy). It returns high within three cycles of `nand_rb` going high.
- R10: `evt_flags` bit 0 is set by a rising edge of `nand_rb`, bit 1 while `nand_rb` is high, and bit 2 by a falling edge. A change of `nand_rb` becomes visible in the flags three clock edges later.
- R11: The flags are sticky. Writing a one to an `evt_clr` bit clears that flag, and a flag whose event occurs in the same cycle stays set.
- R12: `irq` is high exactly when some flag is set and its `evt_ie` bit is high.
- R13: `nand_we_n` and `nand_re_n` are never low together, `nand_cle` and `nand_ale` are never high together, and `nand_dq_oe` is low whenever `nand_re_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_kind | input | 2 | 0 command, 1 address, 2 write data, 3 read data |
| req_space | input | 1 | 0 common timing set, 1 attribute timing set |
| req_data | input | 8 | Byte for command, address or write |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes read byte |
| rd_data | output | 8 | Read byte |
| com_setup | input | 8 | Common space setup cycles |
| com_strobe | input | 8 | Common space strobe count (cycles minus one) |
| com_hold | input | 8 | Common space hold cycles |
| com_hiz | input | 8 | Common space write high-Z cycles |
| att_setup | input | 8 | Attribute space setup cycles |
| att_strobe | input | 8 | Attribute space strobe count (cycles minus one) |
| att_hold | input | 8 | Attribute space hold cycles |
| att_hiz | input | 8 | Attribute space write high-Z cycles |
| cle_re_dly | input | 8 | Minimum cycles from command latch low to read strobe |
| ale_re_dly | input | 8 | Minimum cycles from address latch low to read strobe |
| wait_en | input | 1 | Stall new requests while device is busy |
| evt_ie | input | 3 | Interrupt enables per event flag |
| evt_clr | input | 3 | Write-one-to-clear per event flag |
| evt_flags | output | 3 | Sticky flags: rise, level, fall |
| irq | output | 1 | OR of enabled flags |
| nand_ce_n | output | 1 | Chip enable, low during an access |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe |
| nand_re_n | output | 1 | Read strobe |
| nand_dq_out | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Data bus in |
| nand_rb | input | 1 | Ready (high) / busy (low) |

## Verification
A phase counter that is off by one shows up within the same access: it stretches or shortens the run of low `nand_we_n` or `nand_re_n`, or the run of low `nand_ce_n`, and the bench measures these cycle by cycle. If the latch-to-read gap counters are wrong, the first read strobe appears at the wrong cycle distance from the latch line falling, which is visible within one request pair. Errors in the synchroniser and event logic change the edge at which a flag appears, or let a flag survive its clear. Both are observed at `evt_flags` and `irq` within three cycles.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int unsigned TIME_W = 8;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_WRITE = 2'd2,
    K_READ  = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_GAP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [TIME_W-1:0] setup;
    logic [TIME_W-1:0] strobe;
    logic [TIME_W-1:0] hold;
    logic [TIME_W-1:0] hiz;
  } space_timing_t;
endpackage

// File: rtl/nand_space_select.sv
module nand_space_select
  import nand_seq_pkg::*;
#(
  parameter int unsigned TW = TIME_W
) (
  input  logic [TW-1:0] com_setup,
  input  logic [TW-1:0] com_strobe,
  input  logic [TW-1:0] com_hold,
  input  logic [TW-1:0] com_hiz,
  input  logic [TW-1:0] att_setup,
  input  logic [TW-1:0] att_strobe,
  input  logic [TW-1:0] att_hold,
  input  logic [TW-1:0] att_hiz,
  input  logic          space,
  output space_timing_t sel
);
  space_timing_t set_com, set_att;

  always_comb begin
    set_com = '{setup: com_setup, strobe: com_strobe, hold: com_hold, hiz: com_hiz};
    set_att = '{setup: att_setup, strobe: att_strobe, hold: att_hold, hiz: att_hiz};
    sel     = space ? set_att : set_com;
  end
endmodule

// File: rtl/nand_gap_tracker.sv
module nand_gap_tracker #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_hi,
  output logic [TW-1:0] low_run_next
);
  localparam logic [TW-1:0] SAT = {TW{1'b1}};

  logic [TW-1:0] low_run;

  // Count of consecutive low cycles including the current one, saturating.
  always_comb begin
    if (line_hi)             low_run_next = '0;
    else if (low_run == SAT) low_run_next = SAT;
    else                     low_run_next = low_run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= SAT;
    else        low_run <= low_run_next;
  end
endmodule

// File: rtl/nand_rb_monitor.sv
module nand_rb_monitor #(
  parameter int unsigned NEV = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rb_async,
  input  logic [NEV-1:0] clr,
  output logic           busy,
  output logic [NEV-1:0] flags
);
  logic rb_m, rb_s, rb_d;
  logic [NEV-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_m <= 1'b1;
      rb_s <= 1'b1;
      rb_d <= 1'b1;
    end else begin
      rb_m <= rb_async;
      rb_s <= rb_m;
      rb_d <= rb_s;
    end
  end

  assign busy = !rb_s;

  always_comb begin
    hit    = '0;
    hit[0] = rb_s && !rb_d;
    hit[1] = rb_s;
    hit[2] = !rb_s && rb_d;
  end

  for (genvar i = 0; i < NEV; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (hit[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_seq_pkg::*;
#(
  parameter int unsigned TW = TIME_W,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_data,
  input  space_timing_t sel,
  input  logic          wait_en,
  input  logic          busy,
  input  logic          cle_ok,
  input  logic          ale_ok,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] dq_in,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  seq_state_e    state;
  op_kind_e      kind_q;
  logic [DW-1:0] data_q;
  logic [TW-1:0] strobe_q, hold_q, cnt, hiz_cnt;

  logic     in_acc, accept, gate_ok, hiz_ok;
  op_kind_e dec_kind;

  always_comb begin
    in_acc    = (state == ST_SETUP) || (state == ST_GAP) ||
                (state == ST_STROBE) || (state == ST_HOLD);
    req_ready = (state == ST_IDLE) && !(wait_en && busy);
    accept    = req_valid && req_ready;
    dec_kind  = (state == ST_IDLE) ? op_kind_e'(req_kind) : kind_q;
    hiz_ok    = (state == ST_IDLE) ? (sel.hiz == '0) : (hiz_cnt <= TW'(1));
    case (dec_kind)
      K_READ:  gate_ok = cle_ok && ale_ok;
      K_WRITE: gate_ok = hiz_ok;
      default: gate_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind_q   <= K_CMD;
      data_q   <= '0;
      strobe_q <= '0;
      hold_q   <= '0;
      cnt      <= '0;
      rd_data  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          kind_q   <= op_kind_e'(req_kind);
          data_q   <= req_data;
          strobe_q <= sel.strobe;
          hold_q   <= sel.hold;
          if (sel.setup != '0) begin
            state <= ST_SETUP;
            cnt   <= sel.setup - 1'b1;
          end else if (gate_ok) begin
            state <= ST_STROBE;
            cnt   <= sel.strobe;
          end else begin
            state <= ST_GAP;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            if (gate_ok) begin
              state <= ST_STROBE;
              cnt   <= strobe_q;
            end else begin
              state <= ST_GAP;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: if (gate_ok) begin
          state <= ST_STROBE;
          cnt   <= strobe_q;
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            if (kind_q == K_READ) rd_data <= dq_in;
            if (hold_q != '0) begin
              state <= ST_HOLD;
              cnt   <= hold_q - 1'b1;
            end else begin
              state <= (kind_q == K_READ) ? ST_DONE : ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) state <= (kind_q == K_READ) ? ST_DONE : ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_DONE: if (rd_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // High-impedance window for write data, counted from the first access cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hiz_cnt <= '0;
    else if (accept)           hiz_cnt <= (op_kind_e'(req_kind) == K_WRITE) ? sel.hiz : '0;
    else if (hiz_cnt != '0)    hiz_cnt <= hiz_cnt - 1'b1;
  end

  always_comb begin
    ce_n     = !in_acc;
    cle      = in_acc && (kind_q == K_CMD);
    ale      = in_acc && (kind_q == K_ADDR);
    we_n     = !((state == ST_STROBE) && (kind_q != K_READ));
    re_n     = !((state == ST_STROBE) && (kind_q == K_READ));
    dq_out   = data_q;
    dq_oe    = in_acc && (kind_q != K_READ) && ((kind_q != K_WRITE) || (hiz_cnt == '0));
    rd_valid = (state == ST_DONE);
  end
endmodule

// File: rtl/nand_cycle_sequencer.sv
module nand_cycle_sequencer
  import nand_seq_pkg::*;
#(
  parameter int unsigned TW  = TIME_W,
  parameter int unsigned DW  = 8,
  parameter int unsigned NEV = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_kind,
  input  logic           req_space,
  input  logic [DW-1:0]  req_data,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [DW-1:0]  rd_data,
  input  logic [TW-1:0]  com_setup,
  input  logic [TW-1:0]  com_strobe,
  input  logic [TW-1:0]  com_hold,
  input  logic [TW-1:0]  com_hiz,
  input  logic [TW-1:0]  att_setup,
  input  logic [TW-1:0]  att_strobe,
  input  logic [TW-1:0]  att_hold,
  input  logic [TW-1:0]  att_hiz,
  input  logic [TW-1:0]  cle_re_dly,
  input  logic [TW-1:0]  ale_re_dly,
  input  logic           wait_en,
  input  logic [NEV-1:0] evt_ie,
  input  logic [NEV-1:0] evt_clr,
  output logic [NEV-1:0] evt_flags,
  output logic           irq,
  output logic           nand_ce_n,
  output logic           nand_cle,
  output logic           nand_ale,
  output logic           nand_we_n,
  output logic           nand_re_n,
  output logic [DW-1:0]  nand_dq_out,
  output logic           nand_dq_oe,
  input  logic [DW-1:0]  nand_dq_in,
  input  logic           nand_rb
);
  space_timing_t sel;
  logic          busy;
  logic [TW-1:0] cle_run, ale_run;

  nand_space_select #(.TW(TW)) u_sel (
    .com_setup(com_setup), .com_strobe(com_strobe), .com_hold(com_hold), .com_hiz(com_hiz),
    .att_setup(att_setup), .att_strobe(att_strobe), .att_hold(att_hold), .att_hiz(att_hiz),
    .space(req_space), .sel(sel)
  );

  nand_gap_tracker #(.TW(TW)) u_cle_gap (
    .clk(clk), .rst_n(rst_n), .line_hi(nand_cle), .low_run_next(cle_run)
  );

  nand_gap_tracker #(.TW(TW)) u_ale_gap (
    .clk(clk), .rst_n(rst_n), .line_hi(nand_ale), .low_run_next(ale_run)
  );

  nand_rb_monitor #(.NEV(NEV)) u_rb (
    .clk(clk), .rst_n(rst_n), .rb_async(nand_rb), .clr(evt_clr),
    .busy(busy), .flags(evt_flags)
  );

  nand_phase_fsm #(.TW(TW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_data(req_data),
    .sel(sel), .wait_en(wait_en), .busy(busy),
    .cle_ok(cle_run >= cle_re_dly), .ale_ok(ale_run >= ale_re_dly),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .dq_in(nand_dq_in),
    .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_out(nand_dq_out), .dq_oe(nand_dq_oe)
  );

  assign irq = |(evt_flags & evt_ie);
endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker #(
  parameter int unsigned DW  = 8,
  parameter int unsigned NEV = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           rd_valid,
  input logic           rd_ready,
  input logic [DW-1:0]  rd_data,
  input logic [NEV-1:0] evt_flags,
  input logic [NEV-1:0] evt_clr,
  input logic [NEV-1:0] evt_ie,
  input logic           irq,
  input logic           nand_ce_n,
  input logic           nand_cle,
  input logic           nand_ale,
  input logic           nand_we_n,
  input logic           nand_re_n,
  input logic           nand_dq_oe
);
  p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  p_latch_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  p_no_drive_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);
  p_we_in_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> !nand_ce_n);
  p_rd_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  p_rd_blocks_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !req_ready);
  p_rise_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flags[0] && !evt_clr[0] |=> evt_flags[0]);
  p_fall_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flags[2] && !evt_clr[2] |=> evt_flags[2]);
  p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_flags & evt_ie) == '0) |-> !irq);
endmodule

bind nand_cycle_sequencer nand_seq_checker #(.DW(DW), .NEV(NEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .evt_flags(evt_flags), .evt_clr(evt_clr),
  .evt_ie(evt_ie), .irq(irq), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_dq_oe(nand_dq_oe)
);

// File: tb/nand_cycle_sequencer_tb_top.sv
`timescale 1ns/1ps
module nand_cycle_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       req_valid = 0, req_space = 0, rd_ready = 0, wait_en = 0, nand_rb = 1;
  logic [1:0] req_kind = 0;
  logic [7:0] req_data = 0, nand_dq_in = 0;
  logic [7:0] com_setup = 0, com_strobe = 0, com_hold = 0, com_hiz = 0;
  logic [7:0] att_setup = 0, att_strobe = 0, att_hold = 0, att_hiz = 0;
  logic [7:0] cle_re_dly = 0, ale_re_dly = 0;
  logic [2:0] evt_ie = 0, evt_clr = 0;
  logic       req_ready, rd_valid, irq, nand_ce_n, nand_cle, nand_ale;
  logic       nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] rd_data, nand_dq_out;
  logic [2:0] evt_flags;

  nand_cycle_sequencer dut_i (.*);

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle monitor for latch-to-read gaps.
  int cyc = 0, cle_fall = 0, ale_fall = 0, re_fall = 0;
  logic p_cle = 0, p_ale = 0, p_re = 1;
  always @(negedge clk) begin
    cyc++;
    if (p_cle && !nand_cle) cle_fall = cyc;
    if (p_ale && !nand_ale) ale_fall = cyc;
    if (p_re && !nand_re_n) re_fall = cyc;
    p_cle = nand_cle; p_ale = nand_ale; p_re = nand_re_n;
  end

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic push(input logic [1:0] k, input logic sp, input logic [7:0] d);
    req_valid = 1; req_kind = k; req_space = sp; req_data = d;
    for (int i = 0; i < 500; i++) begin
      if (req_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    req_valid = 0;
  endtask

  task automatic set_space(input logic sp, input int s, input int n, input int h, input int z);
    if (sp) begin
      att_setup = 8'(s); att_strobe = 8'(n); att_hold = 8'(h); att_hiz = 8'(z);
      com_setup = 8'd9; com_strobe = 8'd9; com_hold = 8'd9; com_hiz = 8'd9;
    end else begin
      com_setup = 8'(s); com_strobe = 8'(n); com_hold = 8'(h); com_hiz = 8'(z);
      att_setup = 8'd9; att_strobe = 8'd9; att_hold = 8'd9; att_hiz = 8'd9;
    end
  endtask

  // R2, R3, R4, R5: write-side access shape.
  task automatic t_access(input logic [1:0] k, input logic sp, input logic [7:0] d,
                          input int s, input int n, input int h, input int z);
    int fw = -1, we_cnt = 0, ce_cnt = 0, line_cnt = 0, other_cnt = 0, oe_first = -1;
    int e_fw, e_ce;
    bit dq_ok = 1;
    set_space(sp, s, n, h, z);
    push(k, sp, d);
    for (int i = 0; i < 40; i++) begin
      if (!nand_we_n) begin
        if (fw < 0) fw = i;
        we_cnt++;
        if (nand_dq_out != d || !nand_dq_oe) dq_ok = 0;
      end
      if (!nand_ce_n) ce_cnt++;
      if ((k == 2'd0 && nand_cle) || (k == 2'd1 && nand_ale)) line_cnt++;
      if ((k != 2'd0 && nand_cle) || (k != 2'd1 && nand_ale)) other_cnt++;
      if (nand_dq_oe && oe_first < 0) oe_first = i;
      @(negedge clk);
    end
    e_fw = (k == 2'd2 && z > s) ? z : s;
    e_ce = e_fw + n + 1 + h;
    chk(fw == e_fw, "R2/R4 strobe start", fw, e_fw);
    chk(we_cnt == n + 1, "R2 strobe width", we_cnt, n + 1);
    chk(ce_cnt == e_ce, "R3 hold/ce span", ce_cnt, e_ce);
    chk(line_cnt == ((k == 2'd2) ? 0 : e_ce), "R2 latch line span", line_cnt,
        (k == 2'd2) ? 0 : e_ce);
    chk(other_cnt == 0, "R2 wrong latch line", other_cnt, 0);
    chk(oe_first == ((k == 2'd2) ? z : 0), "R4 bus drive start", oe_first,
        (k == 2'd2) ? z : 0);
    chk(dq_ok, "R2 data on bus at strobe", dq_ok, 1);
    chk(req_ready == 1, "R3 back to idle", req_ready, 1);
  endtask

  // R6, R7, R8: latch command/address then read.
  task automatic t_read(input logic use_ale, input int dly, input int s, input logic [7:0] din);
    int e_gap, gap;
    set_space(0, s, 1, 1, 0);
    nand_dq_in = din;
    if (use_ale) begin ale_re_dly = 8'(dly); cle_re_dly = 0; end
    else         begin cle_re_dly = 8'(dly); ale_re_dly = 0; end
    push(use_ale ? 2'd1 : 2'd0, 0, 8'h30);
    push(2'd3, 0, 8'h00);
    for (int i = 0; i < 400 && !rd_valid; i++) @(negedge clk);
    e_gap = (dly > s + 1) ? dly : s + 1;
    gap = re_fall - (use_ale ? ale_fall : cle_fall);
    chk(gap == e_gap, use_ale ? "R8 ale-to-re gap" : "R7 cle-to-re gap", gap, e_gap);
    chk(rd_valid && rd_data == din, "R6 read data", rd_data, din);
    @(negedge clk); @(negedge clk);
    chk(rd_valid && !req_ready && rd_data == din, "R6 held under back-pressure",
        {rd_valid, req_ready}, 2);
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
    chk(!rd_valid && req_ready, "R6 released after rd_ready", {rd_valid, req_ready}, 1);
  endtask

  task automatic t_reset;
    chk({nand_ce_n, nand_we_n, nand_re_n} == 3'b111, "R1 strobes idle",
        {nand_ce_n, nand_we_n, nand_re_n}, 7);
    chk({nand_cle, nand_ale, nand_dq_oe, rd_valid, irq} == 5'b0, "R1 lines low",
        {nand_cle, nand_ale, nand_dq_oe, rd_valid, irq}, 0);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
  endtask

  task automatic t_wait;
    wait_en = 1; nand_rb = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 0, "R9 stalled while busy", req_ready, 0);
    repeat (4) @(negedge clk);
    chk(req_ready == 0, "R9 still stalled", req_ready, 0);
    nand_rb = 1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R9 resumes when ready", req_ready, 1);
    wait_en = 0;
  endtask

  task automatic t_events;
    evt_clr = 3'b111; @(negedge clk); evt_clr = 0;
    chk(evt_flags == 3'b010, "R10 level flag while high", evt_flags, 2);
    evt_clr = 3'b010; @(negedge clk); evt_clr = 0;
    chk(evt_flags[1] == 1, "R11 set wins over clear", evt_flags[1], 1);
    nand_rb = 0;
    @(negedge clk); @(negedge clk);
    chk(evt_flags[2] == 0, "R10 fall not before third edge", evt_flags[2], 0);
    @(negedge clk);
    chk(evt_flags[2] == 1, "R10 fall flag", evt_flags[2], 1);
    evt_clr = 3'b111; @(negedge clk); evt_clr = 0;
    chk(evt_flags == 3'b000, "R11 clear while low", evt_flags, 0);
    nand_rb = 1;
    repeat (3) @(negedge clk);
    chk(evt_flags == 3'b011, "R10 rise and level flags", evt_flags, 3);
    evt_clr = 3'b001; @(negedge clk); evt_clr = 0;
    chk(evt_flags == 3'b010, "R11 clear rise only", evt_flags, 2);
    evt_ie = 3'b101;
    @(negedge clk);
    chk(irq == 0, "R12 masked flags no irq", irq, 0);
    evt_ie = 3'b010;
    @(negedge clk);
    chk(irq == 1, "R12 enabled flag raises irq", irq, 1);
    evt_ie = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_access(2'd0, 0, 8'h70, 2, 3, 1, 0);
    t_access(2'd1, 1, 8'h5A, 1, 1, 3, 0);
    t_access(2'd2, 1, 8'hC3, 1, 1, 0, 4);
    t_access(2'd2, 0, 8'h81, 3, 0, 2, 1);
    t_access(2'd0, 0, 8'hFF, 0, 0, 0, 0);
    t_read(0, 6, 0, 8'hA5);
    t_read(1, 9, 1, 8'h3C);
    t_read(0, 0, 2, 8'h96);
    t_wait();
    t_events();
    finish_run();
  end
endmodule